// File: doc/BRIEF.md
# Bus-Matching Width Adapter for an 18-bit FIFO

This block sits on both edges of an 18-bit-wide FIFO storage array and lets the producer port and the consumer port each run 9 or 18 bits wide. The two widths are picked separately, so there are four combinations. With a narrow producer and a wide consumer, two successive 9-bit writes are joined into one 18-bit storage word. With a wide producer and a narrow consumer, each 18-bit storage word is handed out as two 9-bit reads. When both sides have the same width, words pass straight through.

The byte order is either big-endian or little-endian. It sets which 9-bit half of a long word is handed out first, and which half a first-written short byte lands in. The two widths and the byte order are captured from configuration pins while the master reset is held. They stay fixed until the next master reset. A separate partial reset throws away any half-assembled or half-delivered word but keeps the captured settings. Everything runs on one clock. The producer, storage-write, storage-read and consumer sides each use a valid/ready handshake.

Top module: `fwa_width_adapter`

## Requirements
- R1: `cfg_in_narrow`, `cfg_out_narrow` and `cfg_big_end` are captured only on clock edges where `rst_n` is low. Changing them afterwards has no effect on behaviour.
- R2: In 18-in/18-out and 9-in/9-out modes, each storage handshake matches one port handshake in the same cycle: `st_wr_valid`=`wr_valid`, `wr_ready`=`st_wr_ready`, `rd_valid`=`st_rd_valid`, `st_rd_ready`=`rd_ready`. In 18/18 mode the data passes through unchanged. In 9/9 mode the data sits in bits [8:0].
- R3: In 9-in/18-out mode, the first byte of a pair is accepted (`wr_ready`=1) without any storage write. The second byte is presented on the storage side in the same cycle. In big-endian mode the first byte goes to bits [17:9]; in little-endian mode it goes to bits [8:0].
- R4: Whenever the producer port is 9 bits wide, `wr_data[17:9]` is ignored. Bits [17:9] of a 9-in/9-out storage word are zero.
- R5: In 18-in/9-out big-endian mode, the first read of a storage word gives bits [17:9] on `rd_data[8:0]`. The second read gives bits [8:0]. `rd_data[17:9]` is zero.
- R6: In 18-in/9-out little-endian mode, bits [8:0] are read first and bits [17:9] second. In either byte order, `st_rd_ready` is high only on the second read of a word.
- R7: A partial reset (`part_rst_n` low) discards a held first byte and restarts splitting at the first half. The captured widths and byte order are kept.
- R8: While either reset is low, `wr_ready`, `st_wr_valid`, `rd_valid` and `st_rd_ready` are all 0.
- R9: In 9-in/18-out mode, a lone trailing byte is never written to storage until its partner is offered. A second byte that meets storage back-pressure is held off (`wr_ready`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, synchronous; captures configuration |
| part_rst_n | input | 1 | Partial reset, active low, synchronous; keeps configuration |
| cfg_in_narrow | input | 1 | 1 = producer port 9 bits wide |
| cfg_out_narrow | input | 1 | 1 = consumer port 9 bits wide |
| cfg_big_end | input | 1 | 1 = high half first |
| wr_valid | input | 1 | Producer word valid |
| wr_ready | output | 1 | Producer word accepted |
| wr_data | input | 18 | Producer data |
| st_wr_valid | output | 1 | Storage write request |
| st_wr_ready | input | 1 | Storage can take a word |
| st_wr_data | output | 18 | Storage write word |
| st_rd_valid | input | 1 | Storage word available |
| st_rd_ready | output | 1 | Storage word consumed |
| st_rd_data | input | 18 | Storage read word |
| rd_valid | output | 1 | Consumer data valid |
| rd_ready | input | 1 | Consumer takes data |
| rd_data | output | 18 | Consumer data |

## Verification
Two events can fall in the same cycle. A partial reset can arrive while the packing register holds a first byte and the producer is already offering the partner byte. The bench writes one byte, then asserts the partial reset with the producer still valid. It then checks that no storage write appears for the next byte, and that the following pair is assembled under the byte order captured at master reset. The same race on the read side is provoked by taking the first half of a word and then resetting. The bench judges it by checking that the first half is delivered again and that `st_rd_ready` stays low.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

   typedef struct packed {
      logic in_narrow;
      logic out_narrow;
      logic big_end;
   } fwa_mode_t;

   typedef enum logic [1:0] {
      FWA_PASS  = 2'd0,
      FWA_PACK  = 2'd1,
      FWA_SPLIT = 2'd2
   } fwa_path_t;

   function automatic fwa_path_t fwa_path_of(input fwa_mode_t m);
      if (m.in_narrow && !m.out_narrow)      return FWA_PACK;
      else if (!m.in_narrow && m.out_narrow) return FWA_SPLIT;
      else                                   return FWA_PASS;
   endfunction

endpackage

// File: rtl/fwa_mode_reg.sv
module fwa_mode_reg
   import fwa_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cfg_in_narrow,
   input  logic      cfg_out_narrow,
   input  logic      cfg_big_end,
   output fwa_mode_t mode_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q.in_narrow  <= cfg_in_narrow;
         mode_q.out_narrow <= cfg_out_narrow;
         mode_q.big_end    <= cfg_big_end;
      end
   end

endmodule

// File: rtl/fwa_packer.sv
module fwa_packer #(
   parameter int HALF_W = 9,
   localparam int WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              big_end,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [HALF_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data
);

   logic [HALF_W-1:0] held_q;
   logic              have_q;

   assign out_valid = have_q & in_valid;
   assign in_ready  = !have_q | out_ready;
   assign out_data  = big_end ? {held_q, in_data} : {in_data, held_q};

   always_ff @(posedge clk) begin
      if (clr) begin
         have_q <= 1'b0;
      end else if (in_valid && in_ready) begin
         if (!have_q) begin
            held_q <= in_data;
            have_q <= 1'b1;
         end else begin
            have_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/fwa_splitter.sv
module fwa_splitter #(
   parameter int HALF_W = 9,
   localparam int WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              big_end,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [HALF_W-1:0] out_data
);

   logic second_q;
   logic take_hi;

   assign take_hi   = big_end ^ second_q;
   assign out_valid = in_valid;
   assign out_data  = take_hi ? in_data[WORD_W-1:HALF_W] : in_data[HALF_W-1:0];
   assign in_ready  = second_q & out_ready;

   always_ff @(posedge clk) begin
      if (clr)                         second_q <= 1'b0;
      else if (in_valid && out_ready)  second_q <= ~second_q;
   end

endmodule

// File: rtl/fwa_width_adapter.sv
module fwa_width_adapter
   import fwa_pkg::*;
#(
   parameter int HALF_W = 9,
   localparam int WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              part_rst_n,
   input  logic              cfg_in_narrow,
   input  logic              cfg_out_narrow,
   input  logic              cfg_big_end,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [WORD_W-1:0] wr_data,
   output logic              st_wr_valid,
   input  logic              st_wr_ready,
   output logic [WORD_W-1:0] st_wr_data,
   input  logic              st_rd_valid,
   output logic              st_rd_ready,
   input  logic [WORD_W-1:0] st_rd_data,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [WORD_W-1:0] rd_data
);

   generate
      if (HALF_W < 1) begin : g_bad_width
         $error("fwa_width_adapter: HALF_W must be at least 1");
      end
   endgenerate

   localparam logic [HALF_W-1:0] HALF_ZERO = '0;

   fwa_mode_t mode_q;
   fwa_path_t path;
   logic      in_rst;
   logic      is_pack, is_split, is_pass;

   logic              pk_in_valid, pk_in_ready, pk_out_valid;
   logic [WORD_W-1:0] pk_out_data;
   logic              sp_in_valid, sp_in_ready, sp_out_valid;
   logic [HALF_W-1:0] sp_out_data;

   logic raw_wr_ready, raw_st_wr_valid, raw_rd_valid, raw_st_rd_ready;

   assign in_rst   = !rst_n || !part_rst_n;
   assign path     = fwa_path_of(mode_q);
   assign is_pack  = (path == FWA_PACK);
   assign is_split = (path == FWA_SPLIT);
   assign is_pass  = (path == FWA_PASS);

   fwa_mode_reg i_mode (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_in_narrow  (cfg_in_narrow),
      .cfg_out_narrow (cfg_out_narrow),
      .cfg_big_end    (cfg_big_end),
      .mode_q         (mode_q)
   );

   assign pk_in_valid = wr_valid & !in_rst & is_pack;

   fwa_packer #(.HALF_W(HALF_W)) i_packer (
      .clk       (clk),
      .clr       (in_rst),
      .big_end   (mode_q.big_end),
      .in_valid  (pk_in_valid),
      .in_ready  (pk_in_ready),
      .in_data   (wr_data[HALF_W-1:0]),
      .out_valid (pk_out_valid),
      .out_ready (st_wr_ready),
      .out_data  (pk_out_data)
   );

   assign sp_in_valid = st_rd_valid & !in_rst & is_split;

   fwa_splitter #(.HALF_W(HALF_W)) i_splitter (
      .clk       (clk),
      .clr       (in_rst),
      .big_end   (mode_q.big_end),
      .in_valid  (sp_in_valid),
      .in_ready  (sp_in_ready),
      .in_data   (st_rd_data),
      .out_valid (sp_out_valid),
      .out_ready (rd_ready),
      .out_data  (sp_out_data)
   );

   // producer / storage-write side
   always_comb begin
      if (is_pack) begin
         raw_st_wr_valid = pk_out_valid;
         raw_wr_ready    = pk_in_ready;
         st_wr_data      = pk_out_data;
      end else begin
         raw_st_wr_valid = wr_valid;
         raw_wr_ready    = st_wr_ready;
         st_wr_data      = (is_pass && mode_q.in_narrow) ?
                           {HALF_ZERO, wr_data[HALF_W-1:0]} : wr_data;
      end
   end

   // storage-read / consumer side
   always_comb begin
      if (is_split) begin
         raw_rd_valid    = sp_out_valid;
         raw_st_rd_ready = sp_in_ready;
         rd_data         = {HALF_ZERO, sp_out_data};
      end else begin
         raw_rd_valid    = st_rd_valid;
         raw_st_rd_ready = rd_ready;
         rd_data         = (is_pass && mode_q.out_narrow) ?
                           {HALF_ZERO, st_rd_data[HALF_W-1:0]} : st_rd_data;
      end
   end

   assign wr_ready    = raw_wr_ready    & !in_rst;
   assign st_wr_valid = raw_st_wr_valid & !in_rst;
   assign rd_valid    = raw_rd_valid    & !in_rst;
   assign st_rd_ready = raw_st_rd_ready & !in_rst;

endmodule

// File: rtl/fwa_width_adapter_chk.sv
module fwa_width_adapter_chk
   import fwa_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      part_rst_n,
   input fwa_mode_t mode_q,
   input logic      is_pack,
   input logic      is_split,
   input logic      is_pass,
   input logic      wr_valid,
   input logic      wr_ready,
   input logic      st_wr_valid,
   input logic      st_wr_ready,
   input logic      st_rd_valid,
   input logic      st_rd_ready,
   input logic      rd_valid,
   input logic      rd_ready
);

   logic any_rst;
   assign any_rst = !rst_n || !part_rst_n;

   always @(posedge clk) begin
      if (any_rst) begin
         a_r8_quiet_in_reset: assert (!wr_ready && !st_wr_valid && !rd_valid && !st_rd_ready)
            else $error("R8 handshake active during reset");
      end
   end

   a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && $past(rst_n)) |-> $stable(mode_q));

   a_r2_pass_through: assert property (@(posedge clk) disable iff (any_rst)
      is_pass |-> (wr_ready == st_wr_ready && st_wr_valid == wr_valid &&
                   rd_valid == st_rd_valid && st_rd_ready == rd_ready));

   a_r3_first_byte_free: assert property (@(posedge clk) disable iff (any_rst)
      (is_pack && wr_valid && !st_wr_valid) |-> wr_ready);

   a_r9_pair_gap: assert property (@(posedge clk) disable iff (any_rst)
      (is_pack && st_wr_valid && st_wr_ready) |=> !st_wr_valid);

   a_r5_second_half_pops: assert property (@(posedge clk) disable iff (any_rst)
      (is_split && rd_valid && rd_ready && !st_rd_ready) |=> (st_rd_ready == rd_ready));

   a_r6_pop_restarts: assert property (@(posedge clk) disable iff (any_rst)
      (is_split && st_rd_valid && st_rd_ready) |=> !st_rd_ready);

   a_r7_held_byte_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!part_rst_n) && part_rst_n && is_pack) |-> !st_wr_valid);

endmodule

bind fwa_width_adapter fwa_width_adapter_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .part_rst_n  (part_rst_n),
   .mode_q      (mode_q),
   .is_pack     (is_pack),
   .is_split    (is_split),
   .is_pass     (is_pass),
   .wr_valid    (wr_valid),
   .wr_ready    (wr_ready),
   .st_wr_valid (st_wr_valid),
   .st_wr_ready (st_wr_ready),
   .st_rd_valid (st_rd_valid),
   .st_rd_ready (st_rd_ready),
   .rd_valid    (rd_valid),
   .rd_ready    (rd_ready)
);

// File: tb/test_fwa_width_adapter.sv
module test_fwa_width_adapter;

   localparam int CLK_PERIOD = 10;
   localparam int HW = 9;
   localparam int WW = 2 * HW;

   logic          clk = 1'b0;
   logic          rst_n, part_rst_n;
   logic          cfg_in_narrow, cfg_out_narrow, cfg_big_end;
   logic          wr_valid, wr_ready;
   logic [WW-1:0] wr_data;
   logic          st_wr_valid, st_wr_ready;
   logic [WW-1:0] st_wr_data;
   logic          st_rd_valid, st_rd_ready;
   logic [WW-1:0] st_rd_data;
   logic          rd_valid, rd_ready;
   logic [WW-1:0] rd_data;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fwa_width_adapter #(.HALF_W(HW)) i_fwa_width_adapter (
      .clk(clk), .rst_n(rst_n), .part_rst_n(part_rst_n),
      .cfg_in_narrow(cfg_in_narrow), .cfg_out_narrow(cfg_out_narrow),
      .cfg_big_end(cfg_big_end),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .st_wr_valid(st_wr_valid), .st_wr_ready(st_wr_ready), .st_wr_data(st_wr_data),
      .st_rd_valid(st_rd_valid), .st_rd_ready(st_rd_ready), .st_rd_data(st_rd_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
   );

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // master reset, then scramble the config pins (R1: they must be ignored)
   task automatic do_mrs(input logic in_n, input logic out_n, input logic be);
      rst_n = 1'b0; part_rst_n = 1'b1;
      cfg_in_narrow = in_n; cfg_out_narrow = out_n; cfg_big_end = be;
      wr_valid = 1'b0; wr_data = '0; st_wr_ready = 1'b1;
      st_rd_valid = 1'b0; st_rd_data = '0; rd_ready = 1'b0;
      tick;
      wr_valid = 1'b1; st_rd_valid = 1'b1; rd_ready = 1'b1;
      #1;
      chk("R8 reset quiet", {wr_ready, st_wr_valid, rd_valid, st_rd_ready}, 4'b0000);
      tick;
      wr_valid = 1'b0; st_rd_valid = 1'b0; rd_ready = 1'b0;
      rst_n = 1'b1;
      cfg_in_narrow = ~in_n; cfg_out_narrow = ~out_n; cfg_big_end = ~be;
      #1;
   endtask

   task automatic t_pass_wide;
      do_mrs(1'b0, 1'b0, 1'b1);
      wr_valid = 1'b1; wr_data = 18'h2A5A5; st_wr_ready = 1'b0; #1;
      chk("R1 wide write kept after pin change", st_wr_data, 18'h2A5A5);
      chk("R2 write valid passes", st_wr_valid, 1);
      chk("R2 write ready follows storage", wr_ready, 0);
      st_wr_ready = 1'b1; #1;
      chk("R2 write ready follows storage hi", wr_ready, 1);
      st_rd_valid = 1'b1; st_rd_data = 18'h3C3C3; rd_ready = 1'b1; #1;
      chk("R2 read data passes", rd_data, 18'h3C3C3);
      chk("R2 read handshake", {rd_valid, st_rd_ready}, 2'b11);
      tick;
      wr_valid = 1'b0; st_rd_valid = 1'b0; rd_ready = 1'b0; #1;
   endtask

   task automatic t_pass_narrow;
      do_mrs(1'b1, 1'b1, 1'b0);
      wr_valid = 1'b1; wr_data = 18'h3FF12; #1;
      chk("R4 narrow write upper ignored", st_wr_data, 18'h00112);
      chk("R2 narrow one-for-one write", {st_wr_valid, wr_ready}, 2'b11);
      st_rd_valid = 1'b1; st_rd_data = 18'h2ABCD; rd_ready = 1'b0; #1;
      chk("R2 narrow read data", rd_data, 18'h001CD);
      chk("R2 narrow read ready follows", {rd_valid, st_rd_ready}, 2'b10);
      tick;
      wr_valid = 1'b0; st_rd_valid = 1'b0; #1;
   endtask

   function automatic logic [WW-1:0] pair(input logic be, input logic [HW-1:0] first,
                                          input logic [HW-1:0] second);
      return be ? {first, second} : {second, first};
   endfunction

   task automatic t_pack(input logic be);
      do_mrs(1'b1, 1'b0, be);
      st_wr_ready = 1'b1;
      wr_valid = 1'b1; wr_data = 18'h3FE05; #1;
      chk("R3 first byte taken without store", {st_wr_valid, wr_ready}, 2'b01);
      tick;
      wr_data = 18'h2A0C3; #1;
      chk("R3 second byte stores", st_wr_valid, 1);
      chk(be ? "R3 big-endian pack" : "R3 little-endian pack",
          st_wr_data, pair(be, 9'h005, 9'h0C3));
      tick;
      wr_valid = 1'b0; #1;
      chk("R3 no store after pair", st_wr_valid, 0);
      // R9: lone trailing byte, then back-pressure on its partner
      wr_valid = 1'b1; wr_data = 18'h00011; tick;
      wr_valid = 1'b0; tick; tick;
      chk("R9 trailing byte held back", st_wr_valid, 0);
      st_wr_ready = 1'b0; wr_valid = 1'b1; wr_data = 18'h00022; #1;
      chk("R9 partner stalled by storage", {st_wr_valid, wr_ready}, 2'b10);
      tick;
      st_wr_ready = 1'b1; #1;
      chk("R9 partner released", wr_ready, 1);
      chk("R9 held pair data", st_wr_data, pair(be, 9'h011, 9'h022));
      tick;
      wr_valid = 1'b0; #1;
   endtask

   task automatic t_split(input logic be);
      logic [HW-1:0] hi, lo;
      hi = 9'h15A; lo = 9'h0E3;
      do_mrs(1'b0, 1'b1, be);
      st_rd_valid = 1'b1; st_rd_data = {hi, lo}; rd_ready = 1'b1; #1;
      chk(be ? "R5 big-endian first half" : "R6 little-endian first half",
          rd_data, {9'h000, be ? hi : lo});
      chk("R6 no pop on first half", {rd_valid, st_rd_ready}, 2'b10);
      tick;
      chk(be ? "R5 big-endian second half" : "R6 little-endian second half",
          rd_data, {9'h000, be ? lo : hi});
      chk("R6 pop on second half", st_rd_ready, 1);
      tick;
      st_rd_data = {9'h1FF, 9'h001}; rd_ready = 1'b0; #1;
      chk("R5 stall holds first half", rd_data, {9'h000, be ? 9'h1FF : 9'h001});
      chk("R6 stall no pop", st_rd_ready, 0);
      tick;
      st_rd_valid = 1'b0; #1;
   endtask

   task automatic t_partial;
      do_mrs(1'b1, 1'b0, 1'b1);
      wr_valid = 1'b1; wr_data = 18'h00055; tick;
      part_rst_n = 1'b0; wr_data = 18'h000AA; #1;
      chk("R8 partial reset quiet", {wr_ready, st_wr_valid}, 2'b00);
      tick;
      part_rst_n = 1'b1; #1;
      chk("R7 held byte discarded", st_wr_valid, 0);
      tick;
      wr_data = 18'h00033; #1;
      chk("R7 big-endian kept across partial reset", st_wr_data, pair(1'b1, 9'h0AA, 9'h033));
      chk("R7 pair stores after partial reset", st_wr_valid, 1);
      tick;
      wr_valid = 1'b0; #1;
      // read side: restart at first half
      do_mrs(1'b0, 1'b1, 1'b0);
      st_rd_valid = 1'b1; st_rd_data = {9'h15A, 9'h0E3}; rd_ready = 1'b1; tick;
      part_rst_n = 1'b0; tick;
      part_rst_n = 1'b1; #1;
      chk("R7 split restarts at first half", rd_data, 18'h000E3);
      chk("R7 no pop after restart", st_rd_ready, 0);
      tick;
      st_rd_valid = 1'b0; rd_ready = 1'b0; #1;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; part_rst_n = 1'b1;
      cfg_in_narrow = 1'b0; cfg_out_narrow = 1'b0; cfg_big_end = 1'b0;
      wr_valid = 1'b0; wr_data = '0; st_wr_ready = 1'b0;
      st_rd_valid = 1'b0; st_rd_data = '0; rd_ready = 1'b0;
      tick;
      t_pass_wide;
      t_pass_narrow;
      t_pack(1'b1);
      t_pack(1'b0);
      t_split(1'b1);
      t_split(1'b0);
      t_partial;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule